// File: doc/BRIEF.md
# Slot-Scheduled Burst Arbiter for a Shared Frame-Memory Bus

This block decides which of five traffic sources owns a shared memory bus for the next burst. Three of the sources move reconstructed pixels (display fetch, motion-compensation reference fetch and motion-compensation write-back). Their traffic is predictable, so in the scheduled mode they get the bus at fixed points of a repeating decoding-time frame. Those points come from a small table loaded through a write port. The other two sources are the compressed-stream FIFOs. Each one raises a request from a comparison of its fill level against a threshold. Between scheduled slots, the arbiter serves them as soon as they ask.

No grant is ever cut short. A burst runs for its full programmed length, and a slot that falls due in the middle of a burst is held as pending until the bus goes idle. A second mode drops the table and arbitrates all five sources by a fixed static priority. This mode is kept as a baseline for comparing bus activity and buffer sizing. The block only issues grants and end-of-burst pulses. Command sequencing for the memory and the data movement happen elsewhere.

Top module: `bus_sched_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets: `grant` goes to 0, `burst_done` goes to 0, `time_now` goes to 0, all table entries become invalid and nothing is pending.
- R2: `time_now` advances by one each cycle. After the value `period-1` it returns to 0. A `period` of 0 or 1 holds it at 0.
- R3: `grant` has at most one bit set. The grant bits are: bit 0 display fetch, bit 1 MC fetch, bit 2 MC write-back, bit 3 stream read, bit 4 stream write. A grant stays unchanged for exactly L cycles, where L is the burst length and a length of 0 means 1. `burst_done` is high only in the last of those cycles.
- R4: After every burst, `grant` is 0 for at least one cycle. The choice is made in an idle cycle, and the chosen grant appears in the next cycle.
- R5: The stream-write source (fed by the host, drained to memory) requests while `bsw_level > bsw_thr`. The stream-read source (filled from memory) requests while `bsr_level < bsr_thr`. Equality raises no request.
- R6: With `sched_mode` high, a valid table entry whose start equals `time_now` becomes pending at the next edge. In an idle cycle, a pending entry wins over both stream requests, and the lowest entry index goes first. Its burst length comes from the table. Table source codes are 0 display, 1 MC fetch, 2 MC write-back.
- R7: With `sched_mode` high, `pix_req` has no effect on `grant`.
- R8: A slot that falls due while a burst is in progress does not interrupt that burst. It is granted in the first idle cycle after the burst ends.
- R9: An entry with its valid bit clear, or with source code 3, never becomes pending.
- R10: With `sched_mode` low, the priority in an idle cycle is `pix_req[0]`, `pix_req[1]`, `pix_req[2]`, then stream read, then stream write. Source i uses burst length `src_len[i*LEN_W +: LEN_W]`. The table is ignored and all pending marks are cleared. The stream sources use the same length fields in both modes.
- R11: A table write replaces the entry and clears its pending mark. The clear wins over a hit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sched_mode | input | 1 | 1: slot table plus stream polling; 0: fixed priority |
| period | input | TIME_W | Length of the decoding-time frame |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | log2(NENT) | Entry being written |
| tbl_valid | input | 1 | Valid bit of the written entry |
| tbl_start | input | TIME_W | Start time of the written entry |
| tbl_src | input | 2 | Source code of the written entry |
| tbl_len | input | LEN_W | Burst length of the written entry |
| pix_req | input | 3 | Pixel source requests, used only in fixed mode |
| bsw_level | input | LVL_W | Stream-write FIFO fill level |
| bsw_thr | input | LVL_W | Stream-write threshold |
| bsr_level | input | LVL_W | Stream-read FIFO fill level |
| bsr_thr | input | LVL_W | Stream-read threshold |
| src_len | input | 5*LEN_W | Per-source burst lengths |
| grant | output | 5 | One-hot bus grant |
| burst_done | output | 1 | High in the last cycle of a burst |
| time_now | output | TIME_W | Decoding-time counter |

## Verification
The assertions assume `period` and the threshold inputs are stable, or at least meaningful, at each cycle they are sampled. The wrap check also assumes `period` never drops below the current count, because a lowered period makes the counter jump back to zero. The stimulus therefore changes `period` only when the counter is at a value that fits the new frame, and changes levels, thresholds and table entries only between clock edges. Grants and `burst_done` are judged against a behavioural model of pending slots and burst counts. Scenarios place slots in the middle of long stream bursts, put two slots on the same time, and include invalid entries and zero-length bursts.

// File: rtl/bsa_pkg.sv
// Shared constants for the slot-scheduled bus arbiter.
// Assumes five sources with the grant bit order below; the fixed-mode
// priority follows the same order (lower index wins).
package bsa_pkg;
    localparam int NSRC     = 5;
    localparam int G_VID    = 0;   // display fetch
    localparam int G_MCR    = 1;   // motion-compensation fetch
    localparam int G_MCW    = 2;   // motion-compensation write-back
    localparam int G_BSR    = 3;   // stream read (memory -> decoder FIFO)
    localparam int G_BSW    = 4;   // stream write (host FIFO -> memory)

    // Source code held in a schedule entry; SLOT_NONE marks a dead entry.
    typedef enum logic [1:0] {
        SLOT_VID  = 2'd0,
        SLOT_MCR  = 2'd1,
        SLOT_MCW  = 2'd2,
        SLOT_NONE = 2'd3
    } slot_src_e;
endpackage

// File: rtl/bsa_timebase.sv
// Decoding-time counter: counts 0 .. period-1 and wraps.
// Assumes period is held steady in normal use; a period of 0 or 1 keeps 0.
module bsa_timebase #(
    parameter int TIME_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] period,
    output logic [TIME_W-1:0] time_now
);
    logic [TIME_W:0] inc;
    logic            wrap;

    // Next count with an extra bit so the wrap compare cannot overflow.
    always_comb begin
        inc  = {1'b0, time_now} + {{TIME_W{1'b0}}, 1'b1};
        wrap = (inc >= {1'b0, period});
    end

    // Advance or wrap the time counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    time_now <= '0;
        else if (wrap) time_now <= '0;
        else           time_now <= inc[TIME_W-1:0];
    end
endmodule

// File: rtl/bsa_fifo_req.sv
// Threshold request for one stream FIFO.
// DRAIN=1: the FIFO empties into memory and asks when level exceeds threshold.
// DRAIN=0: the FIFO is filled from memory and asks when level falls below it.
module bsa_fifo_req #(
    parameter int LVL_W = 8,
    parameter bit DRAIN = 1'b1
) (
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] thr,
    output logic             req
);
    generate
        if (DRAIN) begin : g_drain
            // Request once there is more than a threshold's worth to send.
            always_comb req = (level > thr);
        end else begin : g_fill
            // Request once the buffer runs below its threshold.
            always_comb req = (level < thr);
        end
    endgenerate
endmodule

// File: rtl/bsa_slot_table.sv
// Schedule table with per-entry pending marks.
// An entry becomes pending the edge after its start time matches the
// counter (scheduled mode only). The lowest pending index is offered;
// 'take' clears that offer. Writes clear the written entry's mark.
module bsa_slot_table
    import bsa_pkg::*;
#(
    parameter int NENT   = 16,
    parameter int TIME_W = 10,
    parameter int LEN_W  = 6,
    localparam int IDX_W = $clog2(NENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sched_en,
    input  logic [TIME_W-1:0] time_now,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic [TIME_W-1:0] wr_start,
    input  logic [1:0]        wr_src,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic              take,
    output logic              pend_any,
    output slot_src_e         pick_src,
    output logic [LEN_W-1:0]  pick_len
);
    logic              valid_q [NENT];
    logic [TIME_W-1:0] start_q [NENT];
    slot_src_e         src_q   [NENT];
    logic [LEN_W-1:0]  len_q   [NENT];
    logic [NENT-1:0]   pend_q;
    logic [NENT-1:0]   hit;
    logic [NENT-1:0]   clr;
    logic [IDX_W-1:0]  pick_idx;

    // Per-entry time match; dead or invalid entries never match.
    generate
        for (genvar e = 0; e < NENT; e++) begin : g_hit
            assign hit[e] = sched_en && valid_q[e] && (src_q[e] != SLOT_NONE)
                            && (start_q[e] == time_now);
        end
    endgenerate

    // Lowest-index pending entry is the one offered.
    always_comb begin
        pend_any = 1'b0;
        pick_idx = '0;
        for (int e = NENT - 1; e >= 0; e--) begin
            if (pend_q[e]) begin
                pend_any = 1'b1;
                pick_idx = IDX_W'(e);
            end
        end
        pick_src = src_q[pick_idx];
        pick_len = len_q[pick_idx];
        clr      = '0;
        if (take) clr[pick_idx] = 1'b1;
    end

    // Table storage and pending marks; a write clears its entry last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            for (int e = 0; e < NENT; e++) begin
                valid_q[e] <= 1'b0;
                start_q[e] <= '0;
                src_q[e]   <= SLOT_NONE;
                len_q[e]   <= '0;
            end
        end else begin
            if (!sched_en) pend_q <= '0;
            else           pend_q <= (pend_q & ~clr) | hit;
            if (wr_en) begin
                valid_q[wr_idx] <= wr_valid;
                start_q[wr_idx] <= wr_start;
                src_q[wr_idx]   <= slot_src_e'(wr_src);
                len_q[wr_idx]   <= wr_len;
                pend_q[wr_idx]  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/bsa_burst.sv
// Burst length counter. Loaded on start; flags the final word.
// Assumes start only arrives while no burst is running. Length 0 acts as 1.
module bsa_burst #(
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    output logic             done
);
    logic [LEN_W-1:0] rem_q;

    // Words left in the current burst, counting the present one.
    always_ff @(posedge clk) begin
        if (!rst_n)              rem_q <= '0;
        else if (start)          rem_q <= (len == '0) ? LEN_W'(1) : len;
        else if (rem_q != '0)    rem_q <= rem_q - LEN_W'(1);
    end

    // Final word of the burst.
    assign done = (rem_q == LEN_W'(1));
endmodule

// File: rtl/bus_sched_arbiter.sv
// Non-preemptive arbiter for a shared frame-memory bus.
// Scheduled mode: pending table slots first, then stream FIFOs.
// Fixed mode: static priority over all five sources.
// A decision is taken only in an idle cycle; the grant is registered.
module bus_sched_arbiter
    import bsa_pkg::*;
#(
    parameter int TIME_W = 10,
    parameter int LEN_W  = 6,
    parameter int LVL_W  = 8,
    parameter int NENT   = 16,
    localparam int IDX_W = $clog2(NENT)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sched_mode,
    input  logic [TIME_W-1:0]     period,
    input  logic                  tbl_we,
    input  logic [IDX_W-1:0]      tbl_idx,
    input  logic                  tbl_valid,
    input  logic [TIME_W-1:0]     tbl_start,
    input  logic [1:0]            tbl_src,
    input  logic [LEN_W-1:0]      tbl_len,
    input  logic [2:0]            pix_req,
    input  logic [LVL_W-1:0]      bsw_level,
    input  logic [LVL_W-1:0]      bsw_thr,
    input  logic [LVL_W-1:0]      bsr_level,
    input  logic [LVL_W-1:0]      bsr_thr,
    input  logic [NSRC*LEN_W-1:0] src_len,
    output logic [NSRC-1:0]       grant,
    output logic                  burst_done,
    output logic [TIME_W-1:0]     time_now
);
    logic              bsw_req, bsr_req;
    logic              pend_any;
    slot_src_e         pick_src;
    logic [LEN_W-1:0]  pick_len;
    logic              idle, start, take;
    logic [NSRC-1:0]   sel_oh;
    logic [LEN_W-1:0]  sel_len;
    logic [NSRC-1:0]   gnt_q;

    bsa_timebase #(.TIME_W(TIME_W)) u_time (
        .clk(clk), .rst_n(rst_n), .period(period), .time_now(time_now)
    );

    bsa_fifo_req #(.LVL_W(LVL_W), .DRAIN(1'b1)) u_bsw_req (
        .level(bsw_level), .thr(bsw_thr), .req(bsw_req)
    );

    bsa_fifo_req #(.LVL_W(LVL_W), .DRAIN(1'b0)) u_bsr_req (
        .level(bsr_level), .thr(bsr_thr), .req(bsr_req)
    );

    bsa_slot_table #(.NENT(NENT), .TIME_W(TIME_W), .LEN_W(LEN_W)) u_table (
        .clk(clk), .rst_n(rst_n), .sched_en(sched_mode), .time_now(time_now),
        .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_valid(tbl_valid),
        .wr_start(tbl_start), .wr_src(tbl_src), .wr_len(tbl_len),
        .take(take), .pend_any(pend_any), .pick_src(pick_src),
        .pick_len(pick_len)
    );

    bsa_burst #(.LEN_W(LEN_W)) u_burst (
        .clk(clk), .rst_n(rst_n), .start(start), .len(sel_len),
        .done(burst_done)
    );

    assign idle = (gnt_q == '0);

    // Choose the next owner and its burst length for an idle cycle.
    always_comb begin
        sel_oh  = '0;
        sel_len = '0;
        take    = 1'b0;
        if (sched_mode) begin
            if (pend_any) begin
                sel_oh[int'(pick_src)] = 1'b1;
                sel_len = pick_len;
                take    = idle;
            end else if (bsr_req) begin
                sel_oh[G_BSR] = 1'b1;
                sel_len = src_len[G_BSR*LEN_W +: LEN_W];
            end else if (bsw_req) begin
                sel_oh[G_BSW] = 1'b1;
                sel_len = src_len[G_BSW*LEN_W +: LEN_W];
            end
        end else begin
            for (int i = NSRC - 1; i >= 0; i--) begin
                if ((i < 3 && pix_req[i]) || (i == G_BSR && bsr_req) ||
                    (i == G_BSW && bsw_req)) begin
                    sel_oh  = '0;
                    sel_oh[i] = 1'b1;
                    sel_len = src_len[i*LEN_W +: LEN_W];
                end
            end
        end
    end

    assign start = idle && (sel_oh != '0);

    // Grant register: set in an idle cycle, dropped after the final word.
    always_ff @(posedge clk) begin
        if (!rst_n)          gnt_q <= '0;
        else if (start)      gnt_q <= sel_oh;
        else if (burst_done) gnt_q <= '0;
    end

    assign grant = gnt_q;
endmodule

// File: rtl/bus_sched_arbiter_chk.sv
// Property checker for bus_sched_arbiter, attached by bind below.
// Assumes period only changes to a value above the current count.
module bus_sched_arbiter_chk #(
    parameter int TIME_W = 10,
    parameter int LVL_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        grant,
    input logic              burst_done,
    input logic [TIME_W-1:0] time_now,
    input logic [TIME_W-1:0] period,
    input logic [LVL_W-1:0]  bsw_level,
    input logic [LVL_W-1:0]  bsw_thr
);
    // R3: never two owners at once.
    a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R3: the end pulse only appears during a grant.
    a_r3_done_in_grant: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> (grant != 5'b0));

    // R3: no preemption, a grant holds until its final word.
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant != 5'b0) && !burst_done) |=> (grant == $past(grant)));

    // R4: an idle cycle always follows a burst.
    a_r4_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> (grant == 5'b0));

    // R2: a nonzero count is always the previous count plus one.
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (time_now != '0) |-> (time_now == $past(time_now) + TIME_W'(1)));

    // R2: the count stays below the frame length when the frame exceeds 1.
    a_r2_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(period) && period > TIME_W'(1)) |-> (time_now < period));

    // R5: a stream-write grant starts only after its level exceeded threshold.
    a_r5_bsw_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant == 5'b10000) && ($past(grant) == 5'b0))
            |-> $past(bsw_level > bsw_thr));
endmodule

bind bus_sched_arbiter bus_sched_arbiter_chk #(
    .TIME_W(TIME_W), .LVL_W(LVL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .grant(grant), .burst_done(burst_done),
    .time_now(time_now), .period(period), .bsw_level(bsw_level),
    .bsw_thr(bsw_thr)
);

// File: tb/bus_sched_arbiter_tb.sv
module bus_sched_arbiter_tb;
    localparam int TIME_W = 10;
    localparam int LEN_W  = 6;
    localparam int LVL_W  = 8;
    localparam int NENT   = 16;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                sched_mode = 1'b0;
    logic [TIME_W-1:0]   period = 10'd10;
    logic                tbl_we = 1'b0;
    logic [3:0]          tbl_idx = '0;
    logic                tbl_valid = 1'b0;
    logic [TIME_W-1:0]   tbl_start = '0;
    logic [1:0]          tbl_src = '0;
    logic [LEN_W-1:0]    tbl_len = '0;
    logic [2:0]          pix_req = '0;
    logic [LVL_W-1:0]    bsw_level = '0, bsw_thr = 8'd100;
    logic [LVL_W-1:0]    bsr_level = 8'd200, bsr_thr = 8'd50;
    logic [5*LEN_W-1:0]  src_len = '0;
    logic [4:0]          grant;
    logic                burst_done;
    logic [TIME_W-1:0]   time_now;

    bus_sched_arbiter #(.TIME_W(TIME_W), .LEN_W(LEN_W), .LVL_W(LVL_W),
                        .NENT(NENT)) u_dut (
        .clk(clk), .rst_n(rst_n), .sched_mode(sched_mode), .period(period),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_valid(tbl_valid),
        .tbl_start(tbl_start), .tbl_src(tbl_src), .tbl_len(tbl_len),
        .pix_req(pix_req), .bsw_level(bsw_level), .bsw_thr(bsw_thr),
        .bsr_level(bsr_level), .bsr_thr(bsr_thr), .src_len(src_len),
        .grant(grant), .burst_done(burst_done), .time_now(time_now)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    string tag = "R1";

    // Behavioural model state
    int m_t, m_gnt, m_rem;
    int m_pend[NENT];
    int m_valid[NENT], m_start[NENT], m_src[NENT], m_len[NENT];
    int starts[5];

    function automatic int field_len(int i);
        return int'(src_len[i*LEN_W +: LEN_W]);
    endfunction

    task automatic model_step();
        int hit[NENT];
        int clr, nsrc, nlen;
        if (!rst_n) begin
            m_t = 0; m_gnt = -1; m_rem = 0;
            for (int e = 0; e < NENT; e++) begin
                m_pend[e] = 0; m_valid[e] = 0; m_start[e] = 0;
                m_src[e] = 3; m_len[e] = 0;
            end
            return;
        end
        clr = -1; nsrc = -1; nlen = 0;
        for (int e = 0; e < NENT; e++)
            hit[e] = (sched_mode && m_valid[e] != 0 && m_src[e] != 3 &&
                      m_start[e] == m_t) ? 1 : 0;
        if (m_gnt < 0) begin
            if (sched_mode) begin
                for (int e = 0; e < NENT; e++)
                    if (clr < 0 && m_pend[e] != 0) clr = e;
                if (clr >= 0) begin
                    nsrc = m_src[clr]; nlen = m_len[clr];
                end else if (bsr_level < bsr_thr) begin
                    nsrc = 3; nlen = field_len(3);
                end else if (bsw_level > bsw_thr) begin
                    nsrc = 4; nlen = field_len(4);
                end
            end else begin
                for (int i = 0; i < 3; i++)
                    if (nsrc < 0 && pix_req[i]) nsrc = i;
                if (nsrc < 0 && bsr_level < bsr_thr) nsrc = 3;
                if (nsrc < 0 && bsw_level > bsw_thr) nsrc = 4;
                if (nsrc >= 0) nlen = field_len(nsrc);
            end
            if (nsrc >= 0) begin
                m_gnt = nsrc; m_rem = (nlen == 0) ? 1 : nlen;
                starts[nsrc]++;
            end
        end else if (m_rem == 1) begin
            m_gnt = -1; m_rem = 0;
        end else begin
            m_rem--;
        end
        for (int e = 0; e < NENT; e++) begin
            if (!sched_mode) m_pend[e] = 0;
            else begin
                if (e == clr) m_pend[e] = 0;
                if (hit[e] != 0) m_pend[e] = 1;
            end
        end
        if (tbl_we) begin
            m_pend[tbl_idx]  = 0;
            m_valid[tbl_idx] = int'(tbl_valid);
            m_start[tbl_idx] = int'(tbl_start);
            m_src[tbl_idx]   = int'(tbl_src);
            m_len[tbl_idx]   = int'(tbl_len);
        end
        m_t = (m_t + 1 >= int'(period)) ? 0 : m_t + 1;
    endtask

    task automatic check(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One clock: model advances with present inputs, outputs compared at negedge.
    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        check("grant", int'(grant), (m_gnt < 0) ? 0 : (1 << m_gnt));
        check("burst_done", int'(burst_done), (m_gnt >= 0 && m_rem == 1) ? 1 : 0);
        check("time_now", int'(time_now), m_t);
        tbl_we = 1'b0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic set_len(int i, int v);
        src_len[i*LEN_W +: LEN_W] = LEN_W'(v);
    endtask

    task automatic write_entry(int idx, bit v, int st, int src, int len);
        tbl_we = 1'b1; tbl_idx = 4'(idx); tbl_valid = v;
        tbl_start = TIME_W'(st); tbl_src = 2'(src); tbl_len = LEN_W'(len);
        tick();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 5; i++) starts[i] = 0;
        @(negedge clk);
        // R1: reset state
        tag = "R1";
        set_len(0, 4); set_len(1, 3); set_len(2, 2); set_len(3, 5); set_len(4, 3);
        run(3);
        rst_n = 1'b1;

        // R2: counter wrap with period 10, then period 1 holds zero
        tag = "R2";
        run(25);
        while (time_now != 0) tick();
        period = 10'd1;
        run(5);
        period = 10'd0;
        run(3);
        period = 10'd64;
        run(4);

        // R5: threshold edges, equality raises nothing
        tag = "R5";
        bsw_level = 8'd100; bsr_level = 8'd50;
        run(6);
        bsw_level = 8'd101;
        run(12);
        bsw_level = 8'd0; bsr_level = 8'd49;
        run(12);
        bsr_level = 8'd200;
        run(6);

        // R3/R4: zero-length stream bursts and back-to-back requests
        tag = "R3/R4";
        set_len(4, 0);
        bsw_level = 8'd255;
        run(10);
        set_len(4, 7);
        run(20);
        bsw_level = 8'd0;
        run(8);

        // R10: fixed priority over every source, table ignored
        tag = "R10";
        write_entry(0, 1'b1, 20, 0, 9);
        pix_req = 3'b111; bsr_level = 8'd0; bsw_level = 8'd255;
        run(20);
        pix_req = 3'b110;
        run(15);
        pix_req = 3'b100;
        run(12);
        pix_req = 3'b000;
        run(20);
        bsr_level = 8'd200;
        run(15);
        bsw_level = 8'd0;
        run(10);
        if (starts[0] == 0) begin
            failures++;
            $display("FAIL R10 display fetch never granted: actual=0 expected>0");
        end
        checks++;

        // R6/R8/R9/R7: scheduled mode with slots colliding with stream bursts
        tag = "R6/R8/R9/R7";
        write_entry(0, 1'b1, 5, 0, 32);
        write_entry(1, 1'b1, 50, 1, 4);
        write_entry(2, 1'b1, 50, 2, 2);
        write_entry(3, 1'b1, 30, 3, 6);
        write_entry(4, 1'b0, 40, 0, 6);
        set_len(4, 16); set_len(3, 5);
        while (time_now != 0) tick();
        sched_mode = 1'b1;
        pix_req = 3'b111;
        bsw_level = 8'd255;
        for (int i = 0; i < 5; i++) starts[i] = 0;
        run(200);
        checks++;
        if (starts[1] == 0 || starts[2] == 0 || starts[0] == 0) begin
            failures++;
            $display("FAIL R6 slot sources not all granted: actual=%0d%0d%0d expected=111",
                     starts[0] > 0, starts[1] > 0, starts[2] > 0);
        end
        bsw_level = 8'd0; bsr_level = 8'd0;
        run(40);

        // R11: overwrite an entry while its slot is pending
        tag = "R11";
        set_len(3, 20);
        write_entry(5, 1'b1, 10, 0, 3);
        while (time_now != 13) tick();
        write_entry(5, 1'b0, 10, 0, 3);
        run(80);
        bsr_level = 8'd200;
        run(20);

        // R10: leaving scheduled mode clears pending marks
        tag = "R10";
        write_entry(6, 1'b1, 2, 1, 5);
        while (time_now != 3) tick();
        sched_mode = 1'b0; pix_req = 3'b000;
        run(10);
        sched_mode = 1'b1;
        run(70);

        // R1: reset mid-burst
        tag = "R1";
        bsw_level = 8'd255;
        run(5);
        rst_n = 1'b0;
        run(2);
        rst_n = 1'b1;
        bsw_level = 8'd0;
        run(6);

        finish_run();
    end

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end
endmodule